// File: doc/BRIEF.md
# CAN controller mode handshake

This block sits beside the protocol engine of a CAN controller. It manages the controller's low-power and configuration modes. The CPU raises a sleep request or an initialization request, and the block answers with an acknowledge once the request has actually taken effect. A request cannot be taken back before its acknowledge has been given. Sleep is granted only when the receiver is idle and every transmit buffer is empty. While asleep, a dominant bit seen on the bus can wake the controller, provided wake-up is enabled. In that case the block drops the sleep request itself and raises a wake-up flag.

An initialization request takes effect at once. It forces the transmit pin recessive in the same cycle, drops bus synchronisation, holds the status registers in soft reset, and opens configuration registers for writing once the acknowledge is up. When initialization is released, the block counts recessive bit samples until it has seen a run of eleven. In bus-off state it needs 128 such runs before it declares itself synchronised again. Wait and stop power states of the CPU also force the transmit pin recessive.

Top module: `can_mode_ctrl`

## Requirements
- R1: With the sleep request set, the sleep acknowledge rises on the first clock edge at which the receiver is idle (rx_busy=0) and all transmit buffers are empty (tx_empty=1). It stays high while the request is set, and it falls on the clock edge after the request clears.
- R2: A control write with the sleep bit at 1 is ignored while the wake-up flag is set, so the sleep request stays 0.
- R3: A control write with the sleep bit at 0 is ignored while the sleep acknowledge is low, so the sleep request stays 1. The same write with the acknowledge high clears the request on that edge.
- R4: With the sleep acknowledge high and wake_en=1, a bit strobe with a dominant sample (rx_lvl=0) clears the sleep request and sets the wake-up flag on that edge. With wake_en=0 the same sample has no effect. A pulse on wupif_clr clears the wake-up flag.
- R5: A control write with the init bit at 1 sets the init request on that edge. The init acknowledge follows one clock later. tx_force_rec is high combinationally during the write cycle itself.
- R6: A write with the init bit at 0 is ignored while the init acknowledge is low. Once the request has cleared, the init acknowledge falls one clock later.
- R7: cfg_wr_en is high exactly while both the init request and the init acknowledge are high. stat_srst is high while either of them is high.
- R8: Bus synchronisation is lost on the clock after the init request is registered. Once init has fully ended (or after reset), bus_sync rises on the bit strobe that delivers the 11th consecutive recessive sample. A dominant sample restarts the count.
- R9: With bus_off=1, bus_sync rises only on the strobe that completes the 128th run of 11 recessive samples. One run alone is not enough.
- R10: tx_force_rec is high combinationally whenever cpu_wait_off or cpu_stop is high, and whenever the init request or the init acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wr_sleep | input | 1 | Sleep request value written |
| ctl_wr_init | input | 1 | Init request value written |
| wupif_clr | input | 1 | Clears the wake-up flag |
| wake_en | input | 1 | Wake-up on bus activity enable |
| bit_tick | input | 1 | Bit sample strobe from bit timing |
| rx_lvl | input | 1 | Sampled receive level, 1 = recessive |
| rx_busy | input | 1 | Receiver is inside a frame |
| tx_empty | input | 1 | All transmit buffers empty |
| bus_off | input | 1 | Controller is in bus-off state |
| cpu_wait_off | input | 1 | CPU in wait mode with controller stop-in-wait set |
| cpu_stop | input | 1 | CPU in stop mode |
| sleep_req | output | 1 | Sleep request state |
| sleep_ack | output | 1 | Sleep acknowledge |
| init_req | output | 1 | Init request state |
| init_ack | output | 1 | Init acknowledge |
| wupif | output | 1 | Wake-up flag |
| cfg_wr_en | output | 1 | Configuration registers writable |
| stat_srst | output | 1 | Soft reset for status registers |
| bus_sync | output | 1 | Synchronised to the bus |
| tx_force_rec | output | 1 | Force transmit pin recessive |

## Verification
Each request, flag and synchronisation output is registered, so it changes on the clock edge that samples the causing input. The acknowledges lag their request by one further edge. The bench changes inputs 1 ns after a rising edge, advances one edge, and samples 1 ns later, counting edges exactly. That is how it checks the one-edge lag of acknowledge behind request and the 11th and 1408th strobe of the resync counts. tx_force_rec and cfg_wr_en are combinational, so the bench checks them within the same cycle in which their inputs change.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef struct packed {
    logic wr;
    logic sleep;
    logic init;
  } ctl_wr_t;

  typedef struct packed {
    logic tick;
    logic rec;
  } bit_smp_t;
endpackage

// File: rtl/can_mode_req.sv
module can_mode_req
  import can_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_l,
  input  ctl_wr_t  wr,
  input  bit_smp_t smp,
  input  logic     wupif_clr,
  input  logic     wake_en,
  input  logic     rx_busy,
  input  logic     tx_empty,
  output logic     sleep_q,
  output logic     slpak_q,
  output logic     init_q,
  output logic     initak_q,
  output logic     wupif_q
);
  logic sleep_n, slpak_n, init_n, initak_n, wupif_n;
  logic sleep_en, slpak_en, init_en, initak_en, wupif_en;
  logic wake_hit;

  assign wake_hit = sleep_q & slpak_q & wake_en & smp.tick & ~smp.rec;

  always_comb begin
    sleep_n = sleep_q;
    if (wake_hit) begin
      sleep_n = 1'b0;
    end else if (wr.wr) begin
      if (wr.sleep && !wupif_q) sleep_n = 1'b1;
      else if (!wr.sleep && slpak_q) sleep_n = 1'b0;
    end
    slpak_n = sleep_q & (slpak_q | (~rx_busy & tx_empty));
    init_n = init_q;
    if (wr.wr) begin
      if (wr.init) init_n = 1'b1;
      else if (initak_q) init_n = 1'b0;
    end
    initak_n = init_q;
    wupif_n = wupif_q;
    if (wake_hit) wupif_n = 1'b1;
    else if (wupif_clr) wupif_n = 1'b0;
  end

  assign sleep_en  = sleep_n != sleep_q;
  assign slpak_en  = slpak_n != slpak_q;
  assign init_en   = init_n != init_q;
  assign initak_en = initak_n != initak_q;
  assign wupif_en  = wupif_n != wupif_q;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      sleep_q  <= 1'b0;
      slpak_q  <= 1'b0;
      init_q   <= 1'b0;
      initak_q <= 1'b0;
      wupif_q  <= 1'b0;
    end else begin
      if (sleep_en)  sleep_q  <= sleep_n;
      if (slpak_en)  slpak_q  <= slpak_n;
      if (init_en)   init_q   <= init_n;
      if (initak_en) initak_q <= initak_n;
      if (wupif_en)  wupif_q  <= wupif_n;
    end
  end
endmodule

// File: rtl/can_mode_resync.sv
module can_mode_resync
  import can_mode_pkg::*;
#(
  parameter int RUN_LEN = 11,
  parameter int RUNS    = 128
) (
  input  logic     clk,
  input  logic     rst_l,
  input  logic     hold,
  input  bit_smp_t smp,
  input  logic     bus_off,
  output logic     sync_q
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam int NW = $clog2(RUNS + 1);
  localparam logic [RW-1:0] RUN_LAST  = RW'(RUN_LEN - 1);
  localparam logic [NW-1:0] RUNS_LAST = NW'(RUNS - 1);

  logic [RW-1:0] run_q, run_n;
  logic [NW-1:0] runs_q, runs_n;
  logic          sync_n;
  logic          cnt_en;

  always_comb begin
    run_n  = run_q;
    runs_n = runs_q;
    sync_n = sync_q;
    if (hold) begin
      run_n  = '0;
      runs_n = '0;
      sync_n = 1'b0;
    end else if (smp.tick && !sync_q) begin
      if (!smp.rec) begin
        run_n = '0;
      end else if (run_q == RUN_LAST) begin
        run_n = '0;
        if (!bus_off) begin
          sync_n = 1'b1;
          runs_n = '0;
        end else if (runs_q == RUNS_LAST) begin
          sync_n = 1'b1;
          runs_n = '0;
        end else begin
          runs_n = runs_q + 1'b1;
        end
      end else begin
        run_n = run_q + 1'b1;
      end
    end
  end

  assign cnt_en = hold | (smp.tick & ~sync_q);

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      run_q  <= '0;
      runs_q <= '0;
      sync_q <= 1'b0;
    end else if (cnt_en) begin
      run_q  <= run_n;
      runs_q <= runs_n;
      sync_q <= sync_n;
    end
  end
endmodule

// File: rtl/can_mode_outs.sv
module can_mode_outs
  import can_mode_pkg::*;
(
  input  ctl_wr_t wr,
  input  logic    init_q,
  input  logic    initak_q,
  input  logic    cpu_wait_off,
  input  logic    cpu_stop,
  output logic    cfg_wr_en,
  output logic    stat_srst,
  output logic    tx_force_rec
);
  logic init_now;

  assign init_now     = wr.wr & wr.init;
  assign cfg_wr_en    = init_q & initak_q;
  assign stat_srst    = init_q | initak_q;
  assign tx_force_rec = init_now | init_q | initak_q | cpu_wait_off | cpu_stop;
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int RUN_LEN = 11,
  parameter int RUNS    = 128,
  parameter int RST_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_wr_sleep,
  input  logic ctl_wr_init,
  input  logic wupif_clr,
  input  logic wake_en,
  input  logic bit_tick,
  input  logic rx_lvl,
  input  logic rx_busy,
  input  logic tx_empty,
  input  logic bus_off,
  input  logic cpu_wait_off,
  input  logic cpu_stop,
  output logic sleep_req,
  output logic sleep_ack,
  output logic init_req,
  output logic init_ack,
  output logic wupif,
  output logic cfg_wr_en,
  output logic stat_srst,
  output logic bus_sync,
  output logic tx_force_rec
);
  logic [RST_STG-1:0] rst_sh_q;
  logic               rst_l;
  ctl_wr_t            wr;
  bit_smp_t           smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[RST_STG-2:0], 1'b1};
  end
  assign rst_l = rst_sh_q[RST_STG-1];

  assign wr  = '{wr: ctl_wr, sleep: ctl_wr_sleep, init: ctl_wr_init};
  assign smp = '{tick: bit_tick, rec: rx_lvl};

  can_mode_req u_req (
    .clk      (clk),
    .rst_l    (rst_l),
    .wr       (wr),
    .smp      (smp),
    .wupif_clr(wupif_clr),
    .wake_en  (wake_en),
    .rx_busy  (rx_busy),
    .tx_empty (tx_empty),
    .sleep_q  (sleep_req),
    .slpak_q  (sleep_ack),
    .init_q   (init_req),
    .initak_q (init_ack),
    .wupif_q  (wupif)
  );

  can_mode_resync #(.RUN_LEN(RUN_LEN), .RUNS(RUNS)) u_resync (
    .clk    (clk),
    .rst_l  (rst_l),
    .hold   (stat_srst),
    .smp    (smp),
    .bus_off(bus_off),
    .sync_q (bus_sync)
  );

  can_mode_outs u_outs (
    .wr          (wr),
    .init_q      (init_req),
    .initak_q    (init_ack),
    .cpu_wait_off(cpu_wait_off),
    .cpu_stop    (cpu_stop),
    .cfg_wr_en   (cfg_wr_en),
    .stat_srst   (stat_srst),
    .tx_force_rec(tx_force_rec)
  );
endmodule

module can_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_busy,
  input logic tx_empty,
  input logic wake_en,
  input logic bit_tick,
  input logic rx_lvl,
  input logic cpu_stop,
  input logic sleep_req,
  input logic sleep_ack,
  input logic init_req,
  input logic init_ack,
  input logic wupif,
  input logic bus_sync,
  input logic tx_force_rec
);
  AST_SLPAK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack) |-> $past(sleep_req && !rx_busy && tx_empty)); // R1
  AST_SLP_SET_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |-> $past(!wupif)); // R2
  AST_SLP_CLR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_req) |-> $past(sleep_ack)); // R3
  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wupif) |-> $past(sleep_ack && wake_en && bit_tick && !rx_lvl)); // R4
  AST_INITAK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_req) |=> init_ack); // R5
  AST_INIT_CLR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_req) |-> $past(init_ack)); // R6
  AST_NO_SYNC_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_ack |-> !bus_sync); // R8
  AST_STOP_FORCES_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stop || init_ack) |-> tx_force_rec); // R10
endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (.*);

// File: tb/can_mode_ctrl_tb.sv
`timescale 1ns/1ps
module can_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n, ctl_wr, ctl_wr_sleep, ctl_wr_init, wupif_clr, wake_en;
  logic bit_tick, rx_lvl, rx_busy, tx_empty, bus_off, cpu_wait_off, cpu_stop;
  logic sleep_req, sleep_ack, init_req, init_ack, wupif;
  logic cfg_wr_en, stat_srst, bus_sync, tx_force_rec;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_mode_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_ctl(input logic s, input logic i);
    ctl_wr = 1'b1; ctl_wr_sleep = s; ctl_wr_init = i;
    step();
    ctl_wr = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_wr = 0; ctl_wr_sleep = 0; ctl_wr_init = 0; wupif_clr = 0;
    wake_en = 0; bit_tick = 0; rx_lvl = 1; rx_busy = 0; tx_empty = 1;
    bus_off = 0; cpu_wait_off = 0; cpu_stop = 0;
    #20;
    chk("reset sleep_req", sleep_req, 1'b0);
    chk("reset init_ack", init_ack, 1'b0);
    chk("reset bus_sync", bus_sync, 1'b0);
    chk("reset tx_force_rec", tx_force_rec, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(); step(); step();

    // R8: dominant sample restarts the count of 11
    bit_tick = 1;
    for (int i = 0; i < 5; i++) step();
    rx_lvl = 0; step(); rx_lvl = 1;
    for (int i = 0; i < 10; i++) step();
    chk("R8 ten recessive after dominant", bus_sync, 1'b0);
    step();
    chk("R8 eleventh recessive", bus_sync, 1'b1);
    bit_tick = 0;

    // R1: all four idle/empty combinations
    for (int c = 0; c < 4; c++) begin
      rx_busy = c[0]; tx_empty = c[1];
      wr_ctl(1, 0);
      step();
      chk("R1 ack vs idle/empty", sleep_ack, !c[0] && c[1]);
      if (!sleep_ack) begin
        wr_ctl(0, 0);
        chk("R3 early clear ignored", sleep_req, 1'b1);
        rx_busy = 0; tx_empty = 1;
        step();
        chk("R1 ack once idle", sleep_ack, 1'b1);
      end
      wr_ctl(0, 0);
      chk("R3 clear after ack", sleep_req, 1'b0);
      chk("R1 ack held one clock", sleep_ack, 1'b1);
      step();
      chk("R1 ack drops", sleep_ack, 1'b0);
    end
    rx_busy = 0; tx_empty = 1;

    // R4: wake disabled has no effect
    wr_ctl(1, 0); step();
    bit_tick = 1; rx_lvl = 0; step(); step();
    chk("R4 no wake when disabled", sleep_req, 1'b1);
    chk("R4 no flag when disabled", wupif, 1'b0);
    bit_tick = 0; rx_lvl = 1;
    wake_en = 1;
    bit_tick = 1; rx_lvl = 0; step();
    bit_tick = 0; rx_lvl = 1;
    chk("R4 wake clears sleep", sleep_req, 1'b0);
    chk("R4 wake sets flag", wupif, 1'b1);
    step();
    chk("R4 ack drops after wake", sleep_ack, 1'b0);
    chk("R4 sync unaffected", bus_sync, 1'b1);
    wr_ctl(1, 0);
    chk("R2 sleep set blocked by flag", sleep_req, 1'b0);
    wupif_clr = 1; step(); wupif_clr = 0;
    chk("R4 flag cleared", wupif, 1'b0);
    wr_ctl(1, 0);
    chk("R2 sleep set after flag clear", sleep_req, 1'b1);
    step(); wr_ctl(0, 0); step();
    wake_en = 0;

    // R5/R6/R7: init handshake
    ctl_wr = 1; ctl_wr_sleep = 0; ctl_wr_init = 1; #1;
    chk("R5 tx forced during write", tx_force_rec, 1'b1);
    step();
    chk("R5 init_req set", init_req, 1'b1);
    chk("R5 init_ack not yet", init_ack, 1'b0);
    chk("R7 cfg closed before ack", cfg_wr_en, 1'b0);
    chk("R7 srst on request", stat_srst, 1'b1);
    ctl_wr_init = 0; step(); ctl_wr = 0;
    chk("R6 early init clear ignored", init_req, 1'b1);
    chk("R5 init_ack one clock later", init_ack, 1'b1);
    chk("R8 sync lost", bus_sync, 1'b0);
    chk("R7 cfg open", cfg_wr_en, 1'b1);
    wr_ctl(0, 0);
    chk("R6 init clear", init_req, 1'b0);
    chk("R6 ack held one clock", init_ack, 1'b1);
    chk("R7 cfg closed on release", cfg_wr_en, 1'b0);
    step();
    chk("R6 ack drops", init_ack, 1'b0);
    chk("R7 srst released", stat_srst, 1'b0);
    chk("R10 tx free", tx_force_rec, 1'b0);

    // R9: bus-off needs 128 runs of 11
    bus_off = 1; bit_tick = 1; rx_lvl = 1;
    for (int i = 0; i < 11; i++) step();
    chk("R9 one run not enough", bus_sync, 1'b0);
    for (int i = 0; i < 128 * 11 - 12; i++) step();
    chk("R9 one tick short", bus_sync, 1'b0);
    step();
    chk("R9 synced after 128 runs", bus_sync, 1'b1);
    bit_tick = 0; bus_off = 0;

    // R10: wait/stop force
    cpu_stop = 1; #1;
    chk("R10 stop forces", tx_force_rec, 1'b1);
    cpu_stop = 0; cpu_wait_off = 1; #1;
    chk("R10 wait forces", tx_force_rec, 1'b1);
    cpu_wait_off = 0; #1;
    chk("R10 released", tx_force_rec, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule